// File: doc/BRIEF.md
# Pulse-Signalled Bus Handoff Controller

This block lets other bus masters borrow the local bus from a processor's bus unit. Each external master has one channel: a single active-low line, carried here as an input pin plus an output pin with its own enable. The other master asks for the bus with a one-clock low pulse. This unit answers with a one-clock low grant pulse once the running bus cycle has reached a point where it may legally let go. The bus then stays floated until the other master sends a one-clock release pulse on the same line. After that, one dead clock passes before this side may drive the bus again.

The block does not generate bus cycles itself. The bus sequencer reports its current phase on `t_state` and tells the block whether a locked sequence or the first interrupt acknowledge is in progress. Either of those conditions withholds any grant. When both channels are waiting at a release point, the lower channel index wins. A request that arrives while the other channel owns the bus is kept pending and is served after that ownership has ended, including its dead cycle.

Top module: `bus_handoff_ctl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every `rq_out_n` bit is 1, every `rq_oe` bit is 0, and `bus_float` and `dead_cycle` are 0.
- R2: With the bus idle (`t_state` = 0), a low pulse on `rq_in_n[i]` sampled at clock edge k makes the grant appear after edge k+1: `rq_out_n[i]` = 0 for exactly one cycle.
- R3: `bus_float` rises in the cycle after the grant pulse and stays high until the owner's release pulse has been sampled.
- R4: The release pulse sampled at edge r causes exactly one dead cycle after edge r, with `dead_cycle` = 1 and `bus_float` = 1. After edge r+1 both are 0.
- R5: When both channels hold a pending request at a release point, channel 0 is granted first.
- R6: No grant is issued at a clock edge where `lock_active` is 1.
- R7: No grant is issued at a clock edge where `inta_first` is 1.
- R8: Phase codes on `t_state` are 0 idle, 1 T1, 2 T2, 3 T3, 4 wait, 5 T4. A grant may be decided only at an idle or T4 edge. A request first sampled at idle, T1 or T2 is honoured at the next T4. A request sampled at T3, wait or T4 is not honoured before a later T1 has been sampled.
- R9: No grant is decided at an edge where `t_state` is 1, 2, 3 or 4.
- R10: A request from the non-owning channel during an ownership stays pending. It is granted at the first idle edge after the dead cycle, and never before that.
- R11: `rq_oe[i]` is 1, and `rq_out_n[i]` is 0, only during that channel's grant cycle. A low level on the owner's own line during the grant cycle or the dead cycle is neither a release nor a new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rq_in_n | input | NCH | Sampled level of each channel line, active low |
| rq_out_n | output | NCH | Value driven onto each channel line; low only for a grant |
| rq_oe | output | NCH | Output enable per channel line |
| t_state | input | 3 | Current bus phase from the sequencer |
| lock_active | input | 1 | Locked sequence in progress; withholds grants |
| inta_first | input | 1 | First interrupt acknowledge cycle; withholds grants |
| bus_float | output | 1 | Bus outputs must be floated |
| dead_cycle | output | 1 | The one idle clock that follows a release |

## Verification
With the bus idle, a request pulse produces its grant in the second cycle after the pulse is driven. Float follows in the third cycle. The release pulse produces the dead cycle in the next cycle and returns the bus one cycle after that. A request that meets a T4 is granted in the cycle right after that T4. The bench drives inputs on the falling clock edge. At every falling edge it first advances its own reference model by the edge that has just passed, then compares all four outputs, so each result is checked in the exact cycle it is due. Directed sequences repeat the priority, lock, acknowledge, late-request and queued-request cases with literal expected values at those cycles.

// File: rtl/bus_handoff_pkg.sv
package bus_handoff_pkg;

  typedef enum logic [2:0] {
    TS_IDLE = 3'd0,
    TS_T1   = 3'd1,
    TS_T2   = 3'd2,
    TS_T3   = 3'd3,
    TS_TW   = 3'd4,
    TS_T4   = 3'd5
  } tphase_e;

  typedef enum logic [1:0] {
    HS_OWN   = 2'd0,
    HS_GRANT = 2'd1,
    HS_HOLD  = 2'd2,
    HS_DEAD  = 2'd3
  } hstate_e;

  // A request seen this early in a transfer can still be served at its T4.
  function automatic logic early_enough(input logic [2:0] t);
    return (t == TS_IDLE) || (t == TS_T1) || (t == TS_T2);
  endfunction

  // Edge at which the bus may be handed over.
  function automatic logic release_point(input logic [2:0] t, input logic elig);
    return (t == TS_IDLE) || ((t == TS_T4) && elig);
  endfunction

endpackage

// File: rtl/bus_handoff_chan.sv
module bus_handoff_chan
  import bus_handoff_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_n,
  input  logic       listen,
  input  logic       take,
  input  logic       blocked,
  input  logic [2:0] t_state,
  output logic       ready
);

  logic pend;
  logic elig;
  logic req_seen;

  assign req_seen = listen && !line_n && !pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      elig <= 1'b0;
    end else if (take) begin
      pend <= 1'b0;
      elig <= 1'b0;
    end else if (req_seen) begin
      pend <= 1'b1;
      elig <= early_enough(t_state);
    end else if (pend && (t_state == TS_T1)) begin
      elig <= 1'b1;
    end
  end

  assign ready = pend && !blocked && release_point(t_state, elig);

  AST_PEND_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !take) |=> pend); // R10

  AST_TAKE_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (ready && !blocked)); // R6

endmodule

// File: rtl/bus_handoff_arb.sv
module bus_handoff_arb #(
  parameter int NCH = 2
) (
  input  logic           en,
  input  logic [NCH-1:0] ready,
  output logic [NCH-1:0] grant
);

  always_comb begin
    logic found;
    found = 1'b0;
    grant = '0;
    for (int i = 0; i < NCH; i++) begin
      if (en && ready[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

endmodule

// File: rtl/bus_handoff_ctl.sv
module bus_handoff_ctl
  import bus_handoff_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] rq_in_n,
  output logic [NCH-1:0] rq_out_n,
  output logic [NCH-1:0] rq_oe,
  input  logic [2:0]     t_state,
  input  logic           lock_active,
  input  logic           inta_first,
  output logic           bus_float,
  output logic           dead_cycle
);

  localparam int OW = (NCH > 1) ? $clog2(NCH) : 1;

  hstate_e        st;
  logic [OW-1:0]  owner;
  logic [NCH-1:0] ready;
  logic [NCH-1:0] gnt;
  logic [NCH-1:0] listen;
  logic [OW-1:0]  gidx;
  logic           blocked;
  logic           release_seen;
  logic           grant_cyc;

  function automatic logic [OW-1:0] onehot_index(input logic [NCH-1:0] v);
    logic [OW-1:0] r;
    r = '0;
    for (int i = 0; i < NCH; i++) begin
      if (v[i]) r = OW'(i);
    end
    return r;
  endfunction

  assign blocked = lock_active || inta_first;

  for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
    assign listen[gi] = (st == HS_OWN) || (owner != OW'(gi));
    bus_handoff_chan i_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .line_n  (rq_in_n[gi]),
      .listen  (listen[gi]),
      .take    (gnt[gi]),
      .blocked (blocked),
      .t_state (t_state),
      .ready   (ready[gi])
    );
  end

  bus_handoff_arb #(.NCH(NCH)) i_arb (
    .en    (st == HS_OWN),
    .ready (ready),
    .grant (gnt)
  );

  assign gidx         = onehot_index(gnt);
  assign release_seen = (st == HS_HOLD) && !rq_in_n[owner];
  assign grant_cyc    = (st == HS_GRANT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= HS_OWN;
      owner <= '0;
    end else begin
      case (st)
        HS_OWN: begin
          if (|gnt) begin
            st    <= HS_GRANT;
            owner <= gidx;
          end
        end
        HS_GRANT: st <= HS_HOLD;
        HS_HOLD:  if (release_seen) st <= HS_DEAD;
        default:  st <= HS_OWN;
      endcase
    end
  end

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      rq_oe[i]    = grant_cyc && (owner == OW'(i));
      rq_out_n[i] = !rq_oe[i];
    end
  end

  assign bus_float  = (st == HS_HOLD) || (st == HS_DEAD);
  assign dead_cycle = (st == HS_DEAD);

  AST_GRANT_AT_POINT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_cyc) |-> ($past(t_state) == TS_IDLE || $past(t_state) == TS_T4)); // R9

  AST_NO_GRANT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_cyc) |-> !$past(lock_active)); // R6

  AST_NO_GRANT_INTA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_cyc) |-> !$past(inta_first)); // R7

  AST_PRIO_LOW_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_cyc) |-> (($past(ready) & ((NCH'(1) << owner) - NCH'(1))) == '0)); // R5

  AST_FLOAT_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    grant_cyc |=> bus_float); // R3

  AST_DEAD_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    release_seen |=> (dead_cycle && bus_float)); // R4

  AST_DEAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    dead_cycle |=> (!dead_cycle && !bus_float)); // R4

  AST_OE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rq_oe)); // R11

  AST_GRANT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (|rq_oe) |=> (rq_oe == '0)); // R2

endmodule

// File: tb/test_bus_handoff_ctl.sv
module test_bus_handoff_ctl;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] ln = 2'b11;
  logic [2:0] ts = 3'd0;
  logic       lk = 1'b0;
  logic       ia = 1'b0;
  logic [1:0] out_n;
  logic [1:0] oe;
  logic       flt;
  logic       dead;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state: 0 own, 1 grant, 2 hold, 3 dead
  int m_st = 0;
  int m_own = 0;
  bit m_pend [2];
  bit m_elig [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_handoff_ctl #(.NCH(2)) i_bus_handoff_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .rq_in_n     (ln),
    .rq_out_n    (out_n),
    .rq_oe       (oe),
    .t_state     (ts),
    .lock_active (lk),
    .inta_first  (ia),
    .bus_float   (flt),
    .dead_cycle  (dead)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_st = 0; m_own = 0;
    for (int i = 0; i < 2; i++) begin m_pend[i] = 0; m_elig[i] = 0; end
  endtask

  function automatic bit served(input int i);
    return m_pend[i] && !lk && !ia && (ts == 3'd0 || (ts == 3'd5 && m_elig[i]));
  endfunction

  task automatic model_step();
    int g;
    int nst;
    g = -1;
    if (m_st == 0) begin
      if (served(0)) g = 0;
      else if (served(1)) g = 1;
    end
    nst = m_st;
    case (m_st)
      0: if (g >= 0) nst = 1;
      1: nst = 2;
      2: if (!ln[m_own]) nst = 3;
      default: nst = 0;
    endcase
    for (int i = 0; i < 2; i++) begin
      bit lis;
      lis = (m_st == 0) || (m_own != i);
      if (g == i) begin
        m_pend[i] = 0; m_elig[i] = 0;
      end else if (!m_pend[i] && lis && !ln[i]) begin
        m_pend[i] = 1; m_elig[i] = (ts <= 3'd2);
      end else if (m_pend[i] && ts == 3'd1) begin
        m_elig[i] = 1;
      end
    end
    if (g >= 0) m_own = g;
    m_st = nst;
  endtask

  task automatic compare_model();
    int eo;
    eo = (m_st == 1) ? (1 << m_own) : 0;
    chk("R2", "rq_out_n", out_n, (~eo) & 3);
    chk("R11", "rq_oe", oe, eo);
    chk("R3", "bus_float", flt, (m_st == 2 || m_st == 3) ? 1 : 0);
    chk("R4", "dead_cycle", dead, (m_st == 3) ? 1 : 0);
  endtask

  task automatic tick();
    @(negedge clk);
    if (rst_n) model_step(); else model_reset();
    compare_model();
  endtask

  // owner is in its grant cycle: hold, release pulse, dead, back to own
  task automatic rel(input int ch);
    tick();
    ln = (ch == 0) ? 2'b10 : 2'b01;
    tick();
    ln = 2'b11;
    tick();
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    model_reset();
    repeat (2) @(negedge clk);
    chk("R1", "rq_out_n in reset", out_n, 3);
    chk("R1", "rq_oe in reset", oe, 0);
    chk("R1", "bus_float in reset", flt, 0);
    chk("R1", "dead_cycle in reset", dead, 0);
    rst_n = 1'b1;
    tick();
    chk("R1", "rq_out_n after reset", out_n, 3);
    chk("R1", "bus_float after reset", flt, 0);

    // R2 R3 R4 R11 basic handoff on channel 0
    ln = 2'b10; tick();
    chk("R2", "no grant yet", out_n, 3);
    ln = 2'b11; tick();
    chk("R2", "grant ch0 out", out_n, 2'b10);
    chk("R11", "grant ch0 oe", oe, 2'b01);
    chk("R3", "no float in grant cycle", flt, 0);
    ln = 2'b10; tick();   // own echo during grant cycle
    chk("R11", "echo not a release: float", flt, 1);
    chk("R11", "echo not a release: dead", dead, 0);
    ln = 2'b11; tick();
    chk("R3", "float held", flt, 1);
    tick();
    chk("R3", "float still held", flt, 1);
    ln = 2'b10; tick();
    chk("R4", "dead after release", dead, 1);
    chk("R4", "float in dead", flt, 1);
    tick();               // line kept low through the dead cycle
    chk("R4", "dead over", dead, 0);
    chk("R4", "bus back", flt, 0);
    ln = 2'b11;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R11", "low in dead cycle ignored", out_n, 3);
    end

    // R5 R9 R10 priority and queued request
    ts = 3'd3; ln = 2'b00; tick();
    ln = 2'b11; tick();
    chk("R9", "no grant at T3", out_n, 3);
    ts = 3'd0; tick();
    chk("R5", "ch0 wins", out_n, 2'b10);
    tick();
    ln = 2'b10; tick();
    chk("R10", "ch1 not granted in dead", out_n, 3);
    chk("R4", "dead cycle", dead, 1);
    ln = 2'b11; tick();
    chk("R10", "ch1 not granted at return", out_n, 3);
    chk("R4", "bus returned", flt, 0);
    tick();
    chk("R10", "queued ch1 granted", out_n, 2'b01);
    rel(1);

    // R6 lock withholds
    lk = 1'b1; ln = 2'b01; tick();
    ln = 2'b11;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R6", "no grant while locked", out_n, 3);
    end
    lk = 1'b0; tick();
    chk("R6", "grant after unlock", out_n, 2'b01);
    rel(1);

    // R7 first interrupt acknowledge withholds
    ia = 1'b1; ln = 2'b10; tick();
    ln = 2'b11;
    for (int k = 0; k < 2; k++) begin
      tick();
      chk("R7", "no grant in first ack", out_n, 3);
    end
    ia = 1'b0; tick();
    chk("R7", "grant after ack", out_n, 2'b10);
    rel(0);

    // R8 request at T2 served at the same cycle's T4
    ts = 3'd1; tick();
    ts = 3'd2; ln = 2'b10; tick();
    ln = 2'b11; ts = 3'd3; tick();
    chk("R9", "no grant at T3", out_n, 3);
    ts = 3'd5; tick();
    chk("R8", "early request served at T4", out_n, 2'b10);
    ts = 3'd0; rel(0);

    // R8 request at T3 waits for the next cycle's T4
    ts = 3'd1; tick();
    ts = 3'd2; tick();
    ts = 3'd3; ln = 2'b10; tick();
    ln = 2'b11; ts = 3'd5; tick();
    chk("R8", "late request not served at T4", out_n, 3);
    ts = 3'd1; tick();
    chk("R9", "no grant at T1", out_n, 3);
    ts = 3'd2; tick();
    ts = 3'd3; tick();
    ts = 3'd4; tick();
    chk("R9", "no grant in wait", out_n, 3);
    ts = 3'd5; tick();
    chk("R8", "late request served at next T4", out_n, 2'b10);
    ts = 3'd0; rel(0);

    // constrained random traffic against the reference model
    for (int n = 0; n < 4000; n++) begin
      case (ts)
        3'd0: ts = ($urandom % 3 == 0) ? 3'd1 : 3'd0;
        3'd1: ts = 3'd2;
        3'd2: ts = 3'd3;
        3'd3: ts = ($urandom % 4 == 0) ? 3'd4 : 3'd5;
        3'd4: ts = ($urandom % 2 == 0) ? 3'd4 : 3'd5;
        default: ts = ($urandom % 2 == 0) ? 3'd1 : 3'd0;
      endcase
      if ($urandom % 16 == 0) lk = ~lk;
      ia = ($urandom % 10 == 0);
      ln[0] = ($urandom % 6 != 0);
      ln[1] = ($urandom % 6 != 0);
      tick();
    end

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule